// File: doc/BRIEF.md
# Endian-Selectable Load/Store Lane Steering

This block sits between the load/store port of a 32-bit core and a 32-bit memory data bus. Each request names a byte address, an access size and a direction. The block works out which byte lanes of the bus the access touches. For a store it drives the per-lane write strobes and moves the store data onto those lanes. For a load it takes the addressed bytes from the bus, moves them down to bit 0 and pads the upper bits with zeros.

A run-time select input sets the lane order for the whole bus. In big-endian order the byte at the lowest address of a word is its most significant byte. In little-endian order it is the least significant byte. An access that is not aligned to its own size never reaches memory. The block completes it at once with a fault instead.

Instruction fetches share the port. Their size comes from the core's instruction state rather than from the size input. The memory handshake is a single-cycle valid/ready pair. Memory read data must be valid in the same cycle that the memory side accepts a load. The load result and any fault are reported on a registered response one cycle after the request is accepted.

Top module: `mem_lane_steer`

## Requirements
- R1: After reset, and until a request is accepted, `rsp_valid` and `rsp_fault` are 0.
- R2: In little-endian order (`cfg_big_endian`=0), a byte store at byte offset o (o = `req_addr[1:0]`) sets only `mem_be[o]`. It places `req_wdata[7:0]` on bus bits 8*o+7:8*o.
- R3: In big-endian order (`cfg_big_endian`=1), a byte store at offset o sets only `mem_be[3-o]`. It places `req_wdata[7:0]` on bus lane 3-o, so offset 0 uses bits 31:24.
- R4: A halfword store (`req_size`=01) at offset 0 or 2 sets two adjacent strobes. In little-endian order the lanes are {o+1,o} and data bits 7:0 go to lane o. In big-endian order the lanes are {3-o,2-o} and data bits 15:8 go to lane 3-o.
- R5: A word store (`req_size`=10) at offset 0 sets all four strobes and passes `req_wdata` unchanged in either order.
- R6: A load accepted in cycle n (`req_valid` and `req_ready` high, not a store) raises `rsp_valid` in cycle n+1. In that cycle `rsp_rdata` holds the addressed bytes taken from `mem_rdata`, right-justified and zero-extended, using the lane mapping of R2-style little-endian or R3-style big-endian order. A store or an idle cycle leaves `rsp_valid` low in the next cycle.
- R7: A halfword access with address bit 0 set, or a word access with address bits 1:0 not zero, raises `req_fault`. In that cycle `mem_valid` is 0, all of `mem_be` is 0, and `req_ready` is 1.
- R8: The reserved size code 11 is treated as misaligned for a data access and faults as in R7.
- R9: When `req_fetch` is 1, `req_size` and `req_write` are ignored. The fetch is a word load when `cfg_compact_isa` is 0 and a halfword load when it is 1, and it is checked for alignment by that rule.
- R10: `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R11: A faulting request raises `rsp_valid` and `rsp_fault` in the next cycle, with `rsp_rdata` equal to zero.
- R12: For an aligned request, `req_ready` follows `mem_ready`. `mem_valid` equals `req_valid`, and `mem_write` is 1 only for a non-fetch store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_big_endian | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| cfg_compact_isa | input | 1 | 1 when the core runs 16-bit instructions (halfword fetch) |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request completes this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data, right-justified |
| req_fault | output | 1 | Alignment fault on the current request |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | DATA_W/8 | Per-lane write strobes |
| mem_wdata | output | DATA_W | Lane-placed write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| rsp_valid | output | 1 | Load or fault response |
| rsp_fault | output | 1 | Response reports an alignment fault |
| rsp_rdata | output | DATA_W | Right-justified, zero-extended load data |

## Verification
The hardest case to reach is the one where the size input and the instruction state disagree. An example is a fetch carrying a store flag and a byte or reserved size while the core is in 16-bit state at an odd or half-word offset. Only that case shows whether the size override of R9 really wins over the data-access rules. The bench reaches it with a full sweep. The sweep crosses both lane orders, all four size codes, all four byte offsets, load and store, fetch and data, both instruction states and both `mem_ready` values. For every combination it predicts strobes, placed data and extracted read data byte by byte from the address-to-significance mapping.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Number of bytes covered by a size code (reserved code reports 8).
  function automatic int unsigned size_bytes(input acc_size_e sz);
    return 32'd1 << sz;
  endfunction

  // Size used for an instruction fetch in a given instruction state.
  function automatic acc_size_e fetch_size(input logic compact);
    return compact ? SZ_HALF : SZ_WORD;
  endfunction

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_steer_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int OFS_W  = 2
) (
  input  logic             big_endian,
  input  logic             compact,
  input  logic             is_fetch,
  input  acc_size_e        size_req,
  input  logic [OFS_W-1:0] ofs,
  output acc_size_e        eff_size,
  output logic             misalign,
  output logic [OFS_W-1:0] lane_shift
);

  // Lane shift: little-endian keeps the offset, big-endian mirrors it
  // inside the word for the access width.
  function automatic logic [OFS_W-1:0] calc_shift(input logic be_mode,
                                                  input int unsigned nb,
                                                  input logic [OFS_W-1:0] o);
    int unsigned s;
    if (be_mode) s = NLANES - nb - int'(o);
    else         s = int'(o);
    return OFS_W'(s);
  endfunction

  int unsigned nbytes;
  logic        too_wide;
  logic        off_grid;

  always_comb begin
    eff_size = is_fetch ? fetch_size(compact) : size_req;
    nbytes   = size_bytes(eff_size);
    too_wide = nbytes > NLANES;
    off_grid = (ofs & OFS_W'(nbytes - 1)) != '0;
    misalign = too_wide | off_grid;
    lane_shift = misalign ? '0 : calc_shift(big_endian, nbytes, ofs);
  end

endmodule

// File: rtl/lane_wr_place.sv
module lane_wr_place
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NLANES = 4,
  parameter int OFS_W  = 2
) (
  input  logic              enable,
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  lane_shift,
  input  logic [DATA_W-1:0] wdata,
  output logic [NLANES-1:0] be,
  output logic [DATA_W-1:0] placed
);

  function automatic logic [NLANES-1:0] low_lanes(input acc_size_e sz);
    int unsigned nb;
    nb = size_bytes(sz);
    if (nb >= NLANES) return '1;
    return NLANES'((32'd1 << nb) - 1);
  endfunction

  logic [NLANES-1:0] lane_mask;
  logic [DATA_W-1:0] bit_mask;

  assign lane_mask = low_lanes(size);

  for (genvar g = 0; g < NLANES; g++) begin : g_mask
    assign bit_mask[g*8 +: 8] = {8{lane_mask[g]}};
  end

  assign be     = enable ? (lane_mask << lane_shift) : '0;
  assign placed = (wdata & bit_mask) << {lane_shift, 3'b000};

endmodule

// File: rtl/lane_rd_pick.sv
module lane_rd_pick
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NLANES = 4,
  parameter int OFS_W  = 2
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  lane_shift,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] picked
);

  function automatic logic [DATA_W-1:0] keep_bits(input acc_size_e sz);
    int unsigned nb;
    nb = size_bytes(sz);
    if (nb >= NLANES) return '1;
    return DATA_W'((64'd1 << (nb * 8)) - 1);
  endfunction

  assign picked = (rdata >> {lane_shift, 3'b000}) & keep_bits(size);

endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              cfg_compact_isa,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_fault,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int NLANES = DATA_W / 8;
  localparam int OFS_W  = $clog2(NLANES);

  // Named internal events, also observed by the bound checker.
  logic [OFS_W-1:0]  acc_ofs;
  acc_size_e         eff_size;
  logic              misalign;
  logic [OFS_W-1:0]  lane_shift;
  logic              is_store;
  logic              wr_go;
  logic              rd_done;
  logic [DATA_W-1:0] rd_pick;

  assign acc_ofs  = req_addr[OFS_W-1:0];
  assign is_store = req_write & ~req_fetch;

  lane_align_check #(.NLANES(NLANES), .OFS_W(OFS_W)) u_align (
    .big_endian (cfg_big_endian),
    .compact    (cfg_compact_isa),
    .is_fetch   (req_fetch),
    .size_req   (acc_size_e'(req_size)),
    .ofs        (acc_ofs),
    .eff_size   (eff_size),
    .misalign   (misalign),
    .lane_shift (lane_shift)
  );

  assign wr_go = req_valid & ~misalign & is_store;

  lane_wr_place #(.DATA_W(DATA_W), .NLANES(NLANES), .OFS_W(OFS_W)) u_wr (
    .enable     (wr_go),
    .size       (eff_size),
    .lane_shift (lane_shift),
    .wdata      (req_wdata),
    .be         (mem_be),
    .placed     (mem_wdata)
  );

  lane_rd_pick #(.DATA_W(DATA_W), .NLANES(NLANES), .OFS_W(OFS_W)) u_rd (
    .size       (eff_size),
    .lane_shift (lane_shift),
    .rdata      (mem_rdata),
    .picked     (rd_pick)
  );

  assign req_fault = req_valid & misalign;
  assign req_ready = misalign ? 1'b1 : mem_ready;
  assign mem_valid = req_valid & ~misalign;
  assign mem_write = is_store;
  assign mem_addr  = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  assign rd_done = req_valid & req_ready & (misalign | ~is_store);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      rsp_fault <= rd_done & misalign;
      rsp_rdata <= (rd_done && !misalign) ? rd_pick : '0;
    end
  end

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_compact_isa,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_fetch,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_fault,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [DATA_W/8-1:0] mem_be,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [1:0]        eff_size,
  input logic              wr_go,
  input logic              rd_done
);

  localparam int OFS_W = $clog2(DATA_W / 8);

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fault |-> (mem_be == '0 && !mem_valid && req_ready));

  assert_be_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> ($countones(mem_be) == (1 << eff_size)));

  assert_be_only_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |-> mem_be == '0);

  assert_rsp_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rsp_valid);

  assert_rsp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> !rsp_valid);

  assert_fault_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fault && req_ready) |=> (rsp_valid && rsp_fault && rsp_rdata == '0));

  assert_rsvd_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch && req_size == 2'b11) |-> req_fault);

  assert_fetch_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && !cfg_compact_isa && req_addr[OFS_W-1:0] != '0) |-> req_fault);

  assert_ready_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fault) |-> (req_ready == mem_ready && mem_valid));

endmodule

bind mem_lane_steer lane_steer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_mem_lane_steer.sv
`timescale 1ns/1ps
module test_mem_lane_steer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        cfg_compact_isa = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_fault;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_lane_steer i_mem_lane_steer (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 rsp_valid idle", 32'(rsp_valid), 0);
    chk("R1 rsp_fault idle", 32'(rsp_fault), 0);
    chk("R12 mem_valid idle", 32'(mem_valid), 0);
    @(posedge clk); #1;
    chk("R6 no rsp after idle", 32'(rsp_valid), 0);

    for (int big = 0; big < 2; big++)
    for (int cmp = 0; cmp < 2; cmp++)
    for (int fch = 0; fch < 2; fch++)
    for (int sz = 0; sz < 4; sz++)
    for (int o = 0; o < 4; o++)
    for (int wr = 0; wr < 2; wr++)
    for (int rdy = 0; rdy < 2; rdy++) begin
      int nb;
      bit flt, st, ready, rv;
      logic [3:0]  ebe;
      logic [31:0] ewd, emask, erd, wd, rd, adr;
      string tg;
      @(negedge clk);
      wd  = 32'h1F2E3D4C + 32'(big*7 + cmp*13 + fch*29 + sz*31 + o*37 + wr*41) * 32'h01030507;
      rd  = {wd[15:0], ~wd[31:16]} ^ 32'h5A5A0000;
      adr = 32'h4000_1230 + 32'(o) + 32'(sz << 8);
      cfg_big_endian  = big[0];
      cfg_compact_isa = cmp[0];
      req_valid = 1'b1;
      req_fetch = fch[0];
      req_size  = sz[1:0];
      req_write = wr[0];
      req_addr  = adr;
      req_wdata = wd;
      mem_ready = rdy[0];
      mem_rdata = rd;
      // Expected values from the byte-address mapping.
      if (fch != 0) nb = (cmp != 0) ? 2 : 4;
      else          nb = 1 << sz;
      flt = (nb > 4) || ((o % nb) != 0);
      st  = (wr != 0) && (fch == 0);
      ebe = '0; ewd = '0; emask = '0; erd = '0;
      if (!flt) begin
        for (int k = 0; k < nb; k++) begin
          int a, ln, sg;
          a  = o + k;
          ln = (big != 0) ? 3 - a : a;
          sg = (big != 0) ? nb - 1 - k : k;
          if (st) ebe[ln] = 1'b1;
          ewd[ln*8 +: 8]   = wd[sg*8 +: 8];
          emask[ln*8 +: 8] = 8'hFF;
          erd[sg*8 +: 8]   = rd[ln*8 +: 8];
        end
      end
      ready = flt ? 1'b1 : rdy[0];
      rv    = ready && (flt || !st);
      if (flt)            tg = (sz == 3 && fch == 0) ? "R8" : ((fch != 0) ? "R9" : "R7");
      else if (fch != 0)  tg = "R9";
      else if (nb == 2)   tg = "R4";
      else if (nb == 4)   tg = "R5";
      else                tg = (big != 0) ? "R3" : "R2";
      #1;
      chk({tg, " req_fault"}, 32'(req_fault), 32'(flt));
      chk({tg, " R7 mem_valid"}, 32'(mem_valid), 32'(!flt));
      chk({tg, " R12 req_ready"}, 32'(req_ready), 32'(ready));
      chk({tg, " R12 mem_write"}, 32'(mem_write), 32'(st));
      chk({tg, " mem_be"}, 32'(mem_be), 32'(ebe));
      if (st && !flt) chk({tg, " mem_wdata"}, mem_wdata & emask, ewd);
      chk("R10 mem_addr", mem_addr, {adr[31:2], 2'b00});
      @(posedge clk); #1;
      chk({tg, " R6 rsp_valid"}, 32'(rsp_valid), 32'(rv));
      if (rv) begin
        chk({tg, " R11 rsp_fault"}, 32'(rsp_fault), 32'(flt));
        chk({tg, " R6 rsp_rdata"}, rsp_rdata, flt ? 32'h0 : erd);
      end
    end

    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R6 idle after sweep", 32'(rsp_valid), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule